// File: doc/BRIEF.md
# Staged Reconfiguration Control Register

This block is a slave on a 16-bit request/grant register bus. It holds one 32-bit reconfiguration control word, reached through two bus addresses that each carry one 16-bit half. The control word carries a 24-bit flash image start address and a start bit. When software sets the start bit, the rest of the chip is told to reload the device image from that flash address.

A write to the low half goes only into a staging register. The whole word changes in one step when the high half is written: the staged low half and the new high half land together. If the start bit is set in that high-half write, the block raises a one-cycle start pulse. The pulse appears in the same cycle as the newly committed address on the image address output. The start bit is never stored, so it reads back as 0.

Every request, to any address, is granted one clock after it is first seen, and the grant lasts exactly one clock. Read data is valid during that grant cycle. Addresses other than the two register halves are granted, read as zero and have no effect.

Top module: `recfg_ctrl_regs`

## Requirements
- R1: While reset is asserted, and right after it is released, grant is 0, read data is 0, the image address output is 0 and the start pulse is 0. Reset clears the committed word and the staging register. The reset is asynchronous, so the image address reads 0 while reset is still low.
- R2: A request seen at a clock edge while grant is low gives grant high for exactly one cycle after that edge. Grant is never high unless request was high at the preceding edge.
- R3: A write to address 0x00 changes neither the image address output nor the value read back from address 0x00 or 0x01. It only loads the staging register.
- R4: A write to address 0x01 commits the whole word in one step. The image address output becomes {wdata[7:0], staged low half}, visible in the grant cycle.
- R5: A read of address 0x00 returns committed image address bits 15:0. A read of address 0x01 returns committed bits 23:16 in rdata[7:0] with rdata[15:8] = 0. Read data is valid in the grant cycle and is 0 in every other cycle.
- R6: A write to address 0x01 with wdata[15] = 1 raises the start pulse for exactly one cycle, the grant cycle, while the image address output already shows the new address. A later read of address 0x01 returns rdata[15] = 0.
- R7: A write to address 0x01 with wdata[15] = 0 commits the word but produces no start pulse.
- R8: Any address other than 0x00 and 0x01 is granted, reads as 0 and changes neither the committed word nor the staging register.
- R9: wdata[14:8] of a write to address 0x01 is ignored, and rdata[14:8] of address 0x01 always reads 0.
- R10: The staging register keeps its value after a commit. A second write to address 0x01 with no write to 0x00 in between reuses the same staged low half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address, held until grant |
| bus_wr | input | 1 | 1 = write, 0 = read, held until grant |
| bus_wdata | input | 16 | Write data, held until grant |
| bus_req | input | 1 | Access request, held until grant |
| bus_gnt | output | 1 | One-cycle grant: the access is complete |
| bus_rdata | output | 16 | Read data, valid with grant |
| img_addr | output | 24 | Committed flash image start address |
| recfg_start | output | 1 | One-cycle reconfiguration start pulse |

## Verification
The assertions watch the properties that hold on every cycle: the grant is a single-cycle response to a held request, read data is zero outside a read grant, the start pulse is one cycle wide and falls only inside a grant, and the image address moves only on a commit. Other behaviour depends on the order of accesses, so only the bench's scenarios can show it. That covers the staged half staying invisible until the high half arrives, staged data surviving across commits and accesses to unmapped addresses, the read-only bits dropping out, and reset clearing the staging register as well as the committed word.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
  parameter int unsigned BUS_AW = 8;
  parameter int unsigned BUS_DW = 16;
  parameter int unsigned IMG_AW = 24;

  typedef enum logic [1:0] {
    HALF_NONE = 2'd0,
    HALF_LO   = 2'd1,
    HALF_HI   = 2'd2
  } half_sel_e;
endpackage

// File: rtl/recfg_bus_handshake.sv
module recfg_bus_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic gnt,
  output logic accept
);
  logic gnt_q, gnt_d;

  always_comb begin
    gnt_d = req & ~gnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= 1'b0;
    else        gnt_q <= gnt_d;
  end

  assign accept = gnt_d;
  assign gnt    = gnt_q;

  // R2: grant lasts one cycle
  assert_gnt_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |=> !gnt);
  // R2: grant only follows a request
  assert_gnt_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> $past(req));
endmodule

// File: rtl/recfg_addr_decode.sv
module recfg_addr_decode
  import recfg_pkg::*;
#(
  parameter int unsigned AW       = BUS_AW,
  parameter int unsigned LO_INDEX = 0,
  parameter int unsigned HI_INDEX = 1
) (
  input  logic [AW-1:0] addr,
  output half_sel_e     sel
);
  localparam logic [AW-1:0] LO_A = AW'(LO_INDEX);
  localparam logic [AW-1:0] HI_A = AW'(HI_INDEX);

  always_comb begin
    if (addr == LO_A)      sel = HALF_LO;
    else if (addr == HI_A) sel = HALF_HI;
    else                   sel = HALF_NONE;
  end

  // R8: decode is one-hot over the two halves
  always_comb begin
    assert_decode_exclusive_R8: assert (!(sel == HALF_LO && addr != LO_A));
  end
endmodule

// File: rtl/recfg_regbank.sv
module recfg_regbank
  import recfg_pkg::*;
#(
  parameter int unsigned DW  = BUS_DW,
  parameter int unsigned IAW = IMG_AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           wr,
  input  half_sel_e      sel,
  input  logic [DW-1:0]  wdata,
  output logic [IAW-1:0] img_addr,
  output logic           start
);
  localparam int unsigned HI_KEEP   = IAW - DW;
  localparam int unsigned START_POS = DW - 1;

  logic [DW-1:0]  stage_q, stage_d;
  logic [IAW-1:0] commit_q, commit_d;
  logic           start_q, start_d;
  logic           wr_lo, wr_hi;
  logic           wdata_unused;

  assign wdata_unused = ^wdata[START_POS-1:HI_KEEP];

  always_comb begin
    wr_lo    = accept & wr & (sel == HALF_LO);
    wr_hi    = accept & wr & (sel == HALF_HI);
    stage_d  = stage_q;
    commit_d = commit_q;
    start_d  = 1'b0;
    if (wr_lo) stage_d = wdata;
    if (wr_hi) begin
      commit_d = {wdata[HI_KEEP-1:0], stage_q};
      start_d  = wdata[START_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      commit_q <= '0;
      start_q  <= 1'b0;
    end else begin
      if (wr_lo) stage_q <= stage_d;
      if (wr_hi) commit_q <= commit_d;
      start_q <= start_d;
    end
  end

  assign img_addr = commit_q;
  assign start    = start_q;

  // R6: start pulse is one cycle wide
  assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  // R3: image address moves only after a high-half commit
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_hi) |-> $stable(img_addr));
endmodule

// File: rtl/recfg_readmux.sv
module recfg_readmux
  import recfg_pkg::*;
#(
  parameter int unsigned DW  = BUS_DW,
  parameter int unsigned IAW = IMG_AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           wr,
  input  half_sel_e      sel,
  input  logic [IAW-1:0] img_addr,
  output logic [DW-1:0]  rdata
);
  localparam int unsigned HI_KEEP = IAW - DW;

  logic [DW-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = '0;
    if (accept && !wr) begin
      unique case (sel)
        HALF_LO: rdata_d = img_addr[DW-1:0];
        HALF_HI: rdata_d = {{(DW-HI_KEEP){1'b0}}, img_addr[IAW-1:DW]};
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/recfg_ctrl_regs.sv
module recfg_ctrl_regs
  import recfg_pkg::*;
#(
  parameter int unsigned AW       = BUS_AW,
  parameter int unsigned DW       = BUS_DW,
  parameter int unsigned IAW      = IMG_AW,
  parameter int unsigned LO_INDEX = 0,
  parameter int unsigned HI_INDEX = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_wr,
  input  logic [DW-1:0]  bus_wdata,
  input  logic           bus_req,
  output logic           bus_gnt,
  output logic [DW-1:0]  bus_rdata,
  output logic [IAW-1:0] img_addr,
  output logic           recfg_start
);
  logic      accept;
  half_sel_e sel;

  recfg_bus_handshake u_hs (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (bus_req),
    .gnt    (bus_gnt),
    .accept (accept)
  );

  recfg_addr_decode #(.AW(AW), .LO_INDEX(LO_INDEX), .HI_INDEX(HI_INDEX)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  recfg_regbank #(.DW(DW), .IAW(IAW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .wr       (bus_wr),
    .sel      (sel),
    .wdata    (bus_wdata),
    .img_addr (img_addr),
    .start    (recfg_start)
  );

  recfg_readmux #(.DW(DW), .IAW(IAW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .wr       (bus_wr),
    .sel      (sel),
    .img_addr (img_addr),
    .rdata    (bus_rdata)
  );

  // R6: start pulse only inside a grant cycle
  assert_start_in_gnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    recfg_start |-> bus_gnt);
  // R5: read data is zero outside a grant
  assert_rdata_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_gnt |-> (bus_rdata == '0));
endmodule

// File: tb/recfg_ctrl_regs_tb.sv
module recfg_ctrl_regs_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  addr;
    logic        wr;
    logic [15:0] wdata;
    logic [15:0] exp_rd;
    logic        exp_st;
    logic [23:0] exp_img;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 1'b0, 16'h0000, 16'h0000, 1'b0, 24'h000000}, // R5 read lo after reset
    '{8'h01, 1'b0, 16'h0000, 16'h0000, 1'b0, 24'h000000}, // R5 read hi after reset
    '{8'h00, 1'b1, 16'h1234, 16'h0000, 1'b0, 24'h000000}, // R3 stage only
    '{8'h00, 1'b0, 16'h0000, 16'h0000, 1'b0, 24'h000000}, // R3 staged not visible
    '{8'h01, 1'b1, 16'h00AB, 16'h0000, 1'b0, 24'hAB1234}, // R4 R7 commit no start
    '{8'h00, 1'b0, 16'h0000, 16'h1234, 1'b0, 24'hAB1234}, // R5
    '{8'h01, 1'b0, 16'h0000, 16'h00AB, 1'b0, 24'hAB1234}, // R5
    '{8'h01, 1'b1, 16'h7FCD, 16'h0000, 1'b0, 24'hCD1234}, // R9 ro bits set
    '{8'h01, 1'b0, 16'h0000, 16'h00CD, 1'b0, 24'hCD1234}, // R9 ro bits read 0
    '{8'h00, 1'b1, 16'h5678, 16'h0000, 1'b0, 24'hCD1234}, // R3
    '{8'h01, 1'b1, 16'h8030, 16'h0000, 1'b1, 24'h305678}, // R6 start pulse
    '{8'h01, 1'b0, 16'h0000, 16'h0030, 1'b0, 24'h305678}, // R6 start reads 0
    '{8'h02, 1'b1, 16'hFFFF, 16'h0000, 1'b0, 24'h305678}, // R8 unmapped write
    '{8'h02, 1'b0, 16'h0000, 16'h0000, 1'b0, 24'h305678}, // R8 unmapped read
    '{8'h03, 1'b1, 16'h0000, 16'h0000, 1'b0, 24'h305678}, // R8
    '{8'hFF, 1'b0, 16'h0000, 16'h0000, 1'b0, 24'h305678}, // R8
    '{8'h01, 1'b1, 16'h80EE, 16'h0000, 1'b1, 24'hEE5678}, // R10 R8 staging kept
    '{8'h00, 1'b0, 16'h0000, 16'h5678, 1'b0, 24'hEE5678}  // R10
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic        bus_req;
  logic        bus_gnt;
  logic [15:0] bus_rdata;
  logic [23:0] img_addr;
  logic        recfg_start;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  recfg_ctrl_regs u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .bus_rdata   (bus_rdata),
    .img_addr    (img_addr),
    .recfg_start (recfg_start)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic [7:0] a, input logic w, input logic [15:0] d,
                        output logic [15:0] rd, output logic st, output logic [23:0] img,
                        output int lat, output logic g_after, output logic st_after);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = d; bus_req = 1'b1;
    lat = 0;
    do begin
      @(posedge clk); #1;
      lat++;
    end while (!bus_gnt && lat < 20);
    rd = bus_rdata; st = recfg_start; img = img_addr;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 16'h0000;
    @(posedge clk); #1;
    g_after = bus_gnt; st_after = recfg_start;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic        st, g_after, st_after;
    logic [23:0] img;
    int          lat;

    rst_n = 1'b0; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 16'h0000;
    repeat (3) @(posedge clk);
    #1;
    check("R1 gnt in reset", 32'(bus_gnt), 32'd0);
    check("R1 img in reset", 32'(img_addr), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 rdata after reset", 32'(bus_rdata), 32'd0);
    check("R1 start after reset", 32'(recfg_start), 32'd0);

    // R2: idle bus never grants
    repeat (4) begin
      @(posedge clk); #1;
      check("R2 idle gnt", 32'(bus_gnt), 32'd0);
    end

    for (int i = 0; i < NV; i++) begin
      bus_op(VECS[i].addr, VECS[i].wr, VECS[i].wdata, rd, st, img, lat, g_after, st_after);
      check($sformatf("R2 grant latency v%0d", i), 32'(lat), 32'd1);
      check($sformatf("R2 grant width v%0d", i), 32'(g_after), 32'd0);
      if (!VECS[i].wr) check($sformatf("R5 rdata v%0d", i), 32'(rd), 32'(VECS[i].exp_rd));
      check($sformatf("R6 R7 start v%0d", i), 32'(st), 32'(VECS[i].exp_st));
      check($sformatf("R6 start width v%0d", i), 32'(st_after), 32'd0);
      check($sformatf("R4 img v%0d", i), 32'(img), 32'(VECS[i].exp_img));
    end

    // R1: asynchronous reset mid-run clears committed word and staging
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 img async clear", 32'(img_addr), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    bus_op(8'h01, 1'b0, 16'h0000, rd, st, img, lat, g_after, st_after);
    check("R1 hi read after reset", 32'(rd), 32'd0);
    bus_op(8'h01, 1'b1, 16'h0001, rd, st, img, lat, g_after, st_after);
    check("R1 staging cleared", 32'(img), 32'h010000);
    check("R7 no start", 32'(st), 32'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule